// File: doc/BRIEF.md
# 32-Source Interrupt Aggregator

This block collects up to 32 interrupt request lines from peripherals and folds them into one interrupt request toward a processor. Each source is captured into a status bit according to a sense type chosen per source when the block is built: rising edge, falling edge, active-high level or active-low level. Software masks sources with an enable word and arms the output through a two-bit arming register. It clears captured events by writing ones to an acknowledge word and finds the source to service by reading a vector word.

The register port is a plain single-cycle word interface. A write takes effect on the clock edge where `reg_wr` is high. Read data is presented combinationally for whatever offset sits on `reg_addr`. Edge sources are sampled into a register and compared with the sample from the cycle before. Level sources raise their status bit on every cycle they are active, so software must service the device before it acknowledges the source.

Top module: `irq_gather_ctrl`

## Requirements
- R1: After reset the status, enable and arming words read zero, `irq_out` is low and the vector word reads 0xFFFFFFFF.
- R2: A write to byte offset 0x08 replaces the enable word, and reading offset 0x08 returns it.
- R3: Writing a mask to offset 0x10 sets the enable bits that are one in the mask. Writing a mask to offset 0x14 clears them. Enable bits written as zero keep their value.
- R4: Sense code 0 (rising edge) and code 1 (falling edge) set the source's status bit (offset 0x00) on the second clock edge after the input makes that transition. The bit then stays set after the input returns to idle.
- R5: Sense code 2 (active high) and code 3 (active low) set the status bit while the input is active. An acknowledge while the input is still active leaves the bit set. Once the input is inactive, an acknowledge clears it.
- R6: Writing to offset 0x0C clears the status bits written as one and leaves those written as zero. Writing 0xFFFFFFFF clears every edge-captured bit.
- R7: If an edge transition and an acknowledge of the same source are registered on the same clock edge, the status bit ends up set.
- R8: Offset 0x04 reads the status word ANDed with the enable word.
- R9: `irq_out` is high exactly when both bits of the arming word (offset 0x1C, bits 1:0) are one and at least one pending bit is set.
- R10: Offset 0x18 reads the index of the lowest-numbered pending source, or 0xFFFFFFFF when none is pending.
- R11: Writes to offsets 0x00, 0x04 and 0x18 change no state. Offsets 0x0C, 0x10 and 0x14 read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| src_in | input | NUM_SRC | Interrupt request lines |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 5 | Byte offset of the register word |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` |
| irq_out | output | 1 | Combined interrupt request |

## Verification
The hardest situation to reach from the ports is an acknowledge that lands on the same clock edge as the transition it would otherwise erase. Because of the two-register sampling path, the write must be issued exactly one clock after the input changes. The bench does this by issuing the acknowledge write right after the transition. Level sources are also acknowledged while still held active, to show that the bit comes back. A randomized phase then mixes input toggles with every kind of write while a behavioural model is compared on every cycle.

// File: rtl/irqg_pkg.sv
package irqg_pkg;
    localparam int REG_W = 32;

    typedef enum logic [1:0] {
        SENSE_RISE = 2'd0,
        SENSE_FALL = 2'd1,
        SENSE_HIGH = 2'd2,
        SENSE_LOW  = 2'd3
    } sense_e;

    typedef enum logic [2:0] {
        W_STAT  = 3'd0,
        W_PEND  = 3'd1,
        W_EN    = 3'd2,
        W_ACK   = 3'd3,
        W_SETEN = 3'd4,
        W_CLREN = 3'd5,
        W_VEC   = 3'd6,
        W_ARM   = 3'd7
    } word_e;
endpackage

// File: rtl/irqg_capture.sv
module irqg_capture
    import irqg_pkg::*;
#(
    parameter int                     NUM_SRC   = 32,
    parameter logic [2*NUM_SRC-1:0]   SENSE_MAP = '0
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] src_in,
    input  logic [NUM_SRC-1:0] ack_mask,
    output logic [NUM_SRC-1:0] status
);
    function automatic logic [NUM_SRC-1:0] idle_levels();
        logic [NUM_SRC-1:0] v;
        for (int i = 0; i < NUM_SRC; i++) begin
            v[i] = (SENSE_MAP[2*i +: 2] == SENSE_FALL) || (SENSE_MAP[2*i +: 2] == SENSE_LOW);
        end
        return v;
    endfunction

    localparam logic [NUM_SRC-1:0] IDLE = idle_levels();

    typedef struct packed {
        logic [NUM_SRC-1:0] smp;
        logic [NUM_SRC-1:0] prev;
        logic [NUM_SRC-1:0] stat;
    } cap_s;

    cap_s               cap_d, cap_q;
    logic [NUM_SRC-1:0] ev;

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_sense
        localparam logic [1:0] S = SENSE_MAP[2*g +: 2];
        if (S == SENSE_RISE) begin : g_rise
            assign ev[g] = cap_q.smp[g] & ~cap_q.prev[g];
        end else if (S == SENSE_FALL) begin : g_fall
            assign ev[g] = ~cap_q.smp[g] & cap_q.prev[g];
        end else if (S == SENSE_HIGH) begin : g_high
            assign ev[g] = cap_q.smp[g];
        end else begin : g_low
            assign ev[g] = ~cap_q.smp[g];
        end
    end

    always_comb begin
        cap_d      = cap_q;
        cap_d.smp  = src_in;
        cap_d.prev = cap_q.smp;
        cap_d.stat = (cap_q.stat & ~ack_mask) | ev;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cap_q.smp  <= IDLE;
            cap_q.prev <= IDLE;
            cap_q.stat <= '0;
        end else begin
            cap_q <= cap_d;
        end
    end

    assign status = cap_q.stat;

    // A detected event is never lost, even against an acknowledge (R7, R4, R5)
    p_event_kept_r7: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst)) |-> ((cap_q.stat & $past(ev)) == $past(ev)));

    // Acknowledged bits without a new event are cleared (R6)
    p_ack_clears_r6: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst)) |-> ((cap_q.stat & $past(ack_mask & ~ev)) == '0));
endmodule

// File: rtl/irqg_prio.sv
module irqg_prio #(
    parameter int NUM_SRC = 32,
    localparam int IDXW   = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] req,
    output logic               found,
    output logic [IDXW-1:0]    idx
);
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (req[i]) begin
                found = 1'b1;
                idx   = IDXW'(i);
            end
        end
    end

    logic [NUM_SRC-1:0] below_mask;
    always_comb begin
        below_mask = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            below_mask[i] = (i < int'(idx));
        end
    end

    // Reported source is requesting and nothing below it is (R10)
    p_lowest_r10: assert property (@(posedge clk) disable iff (rst)
        found |-> (req[idx] && ((req & below_mask) == '0)));

    // Nothing requesting means nothing found (R10)
    p_none_r10: assert property (@(posedge clk) disable iff (rst)
        (req == '0) |-> !found);
endmodule

// File: rtl/irq_gather_ctrl.sv
module irq_gather_ctrl
    import irqg_pkg::*;
#(
    parameter int                   NUM_SRC   = 32,
    parameter logic [2*NUM_SRC-1:0] SENSE_MAP = 64'hE4E4_E4E4_E4E4_E4E4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] src_in,
    input  logic               reg_wr,
    input  logic [4:0]         reg_addr,
    input  logic [REG_W-1:0]   reg_wdata,
    output logic [REG_W-1:0]   reg_rdata,
    output logic               irq_out
);
    localparam int IDXW = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

    typedef struct packed {
        logic [NUM_SRC-1:0] en;
        logic [1:0]         arm;
    } ctl_s;

    ctl_s               ctl_d, ctl_q;
    word_e              word;
    logic               aligned;
    logic [NUM_SRC-1:0] wmask, ack_mask, status, pend;
    logic               found;
    logic [IDXW-1:0]    idx;

    assign aligned = (reg_addr[1:0] == 2'b00);
    assign word    = word_e'(reg_addr[4:2]);
    assign wmask   = reg_wdata[NUM_SRC-1:0];

    always_comb begin
        ack_mask = '0;
        if (reg_wr && aligned && word == W_ACK) begin
            ack_mask = wmask;
        end
    end

    irqg_capture #(
        .NUM_SRC  (NUM_SRC),
        .SENSE_MAP(SENSE_MAP)
    ) u_cap (
        .clk     (clk),
        .rst     (rst),
        .src_in  (src_in),
        .ack_mask(ack_mask),
        .status  (status)
    );

    assign pend = status & ctl_q.en;

    irqg_prio #(
        .NUM_SRC(NUM_SRC)
    ) u_prio (
        .clk  (clk),
        .rst  (rst),
        .req  (pend),
        .found(found),
        .idx  (idx)
    );

    always_comb begin
        ctl_d = ctl_q;
        if (reg_wr && aligned) begin
            unique case (word)
                W_EN:    ctl_d.en  = wmask;
                W_SETEN: ctl_d.en  = ctl_q.en | wmask;
                W_CLREN: ctl_d.en  = ctl_q.en & ~wmask;
                W_ARM:   ctl_d.arm = reg_wdata[1:0];
                default: ctl_d     = ctl_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    always_comb begin
        reg_rdata = '0;
        if (aligned) begin
            unique case (word)
                W_STAT:  reg_rdata[NUM_SRC-1:0] = status;
                W_PEND:  reg_rdata[NUM_SRC-1:0] = pend;
                W_EN:    reg_rdata[NUM_SRC-1:0] = ctl_q.en;
                W_VEC:   reg_rdata = found ? REG_W'(idx) : '1;
                W_ARM:   reg_rdata[1:0] = ctl_q.arm;
                default: reg_rdata = '0;
            endcase
        end
    end

    assign irq_out = (&ctl_q.arm) & (|pend);

    // Set port never drops an enable and sets every requested one (R3)
    p_set_en_r3: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(reg_wr && aligned && word == W_SETEN))
        |-> ((ctl_q.en & ($past(ctl_q.en) | $past(wmask))) == ($past(ctl_q.en) | $past(wmask))));

    // Clear port removes requested enables and keeps the rest (R3)
    p_clr_en_r3: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(reg_wr && aligned && word == W_CLREN))
        |-> (ctl_q.en == ($past(ctl_q.en) & ~$past(wmask))));

    // Read-only words take no state (R11)
    p_ro_write_r11: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(reg_wr && (word == W_STAT || word == W_PEND || word == W_VEC)))
        |-> $stable(ctl_q));

    // The output needs a pending source that the vector can name (R9)
    p_out_has_vec_r9: assert property (@(posedge clk) disable iff (rst)
        irq_out |-> (found && pend[idx]));
endmodule

// File: tb/sim_irq_gather_ctrl.sv
module sim_irq_gather_ctrl;
    localparam int          N     = 32;
    localparam logic [63:0] SMAP  = 64'hE4E4_E4E4_E4E4_E4E4;
    localparam logic [31:0] IDLEV = 32'hAAAA_AAAA;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] src_in = IDLEV;
    logic        reg_wr = 1'b0;
    logic [4:0]  reg_addr = 5'd0;
    logic [31:0] reg_wdata = 32'd0;
    logic [31:0] reg_rdata;
    logic        irq_out;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    irq_gather_ctrl #(.NUM_SRC(N), .SENSE_MAP(SMAP)) u0 (
        .clk(clk), .rst(rst), .src_in(src_in), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq_out(irq_out)
    );

    // Behavioural reference model
    logic [31:0] m_smp, m_prev, m_stat, m_en;
    logic [1:0]  m_arm;

    function automatic int sense_of(int i);
        return int'(SMAP[2*i +: 2]);
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_smp = IDLEV; m_prev = IDLEV; m_stat = '0; m_en = '0; m_arm = '0;
        end else begin
            logic [31:0] ev, ackv;
            for (int i = 0; i < N; i++) begin
                case (sense_of(i))
                    0: ev[i] = m_smp[i] && !m_prev[i];
                    1: ev[i] = !m_smp[i] && m_prev[i];
                    2: ev[i] = m_smp[i];
                    default: ev[i] = !m_smp[i];
                endcase
            end
            ackv = (reg_wr && reg_addr == 5'h0C) ? reg_wdata : 32'd0;
            m_stat = (m_stat & ~ackv) | ev;
            m_prev = m_smp;
            m_smp  = src_in;
            if (reg_wr) begin
                case (reg_addr)
                    5'h08: m_en = reg_wdata;
                    5'h10: m_en = m_en | reg_wdata;
                    5'h14: m_en = m_en & ~reg_wdata;
                    5'h1C: m_arm = reg_wdata[1:0];
                    default: ;
                endcase
            end
        end
    end

    function automatic logic [31:0] model_read(logic [4:0] a);
        logic [31:0] p;
        p = m_stat & m_en;
        case (a)
            5'h00: return m_stat;
            5'h04: return p;
            5'h08: return m_en;
            5'h18: begin
                for (int i = 0; i < N; i++) if (p[i]) return i;
                return 32'hFFFF_FFFF;
            end
            5'h1C: return {30'd0, m_arm};
            default: return 32'd0;
        endcase
    endfunction

    function automatic string tag_of(logic [4:0] a);
        case (a)
            5'h00: return "R4/R5/R6 status";
            5'h04: return "R8 pending";
            5'h08: return "R2 enable";
            5'h18: return "R10 vector";
            5'h1C: return "R9 arm";
            default: return "R11 write-only";
        endcase
    endfunction

    // Per-cycle comparison against the model, away from the active edge
    always @(negedge clk) begin
        if (!rst && !done) begin
            logic [31:0] er;
            logic        ei;
            er = model_read(reg_addr);
            ei = (m_arm == 2'b11) && ((m_stat & m_en) != 0);
            checks += 2;
            if (reg_rdata !== er) begin
                failures++;
                $display("FAIL %s addr=%h actual=%h expected=%h", tag_of(reg_addr), reg_addr, reg_rdata, er);
            end
            if (irq_out !== ei) begin
                failures++;
                $display("FAIL R9 irq_out actual=%b expected=%b", irq_out, ei);
            end
        end
    end

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(posedge clk); #2;
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk); #2;
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, input logic [31:0] exp, input string tag);
        @(posedge clk); #2;
        reg_addr = a;
        @(negedge clk);
        checks++;
        if (reg_rdata !== exp) begin
            failures++;
            $display("FAIL %s addr=%h actual=%h expected=%h", tag, a, reg_rdata, exp);
        end
    endtask

    task automatic chk_irq(input logic exp, input string tag);
        @(negedge clk);
        checks++;
        if (irq_out !== exp) begin
            failures++;
            $display("FAIL %s irq_out actual=%b expected=%b", tag, irq_out, exp);
        end
    endtask

    task automatic drive(input logic [31:0] v);
        @(posedge clk); #2;
        src_in = v;
    endtask

    task automatic settle();
        @(posedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #2 rst = 1'b0;

        rd(5'h00, 32'h0, "R1 status after reset");
        rd(5'h08, 32'h0, "R1 enable after reset");
        rd(5'h1C, 32'h0, "R1 arm after reset");
        rd(5'h18, 32'hFFFF_FFFF, "R1 vector after reset");
        chk_irq(1'b0, "R1");

        wr(5'h1C, 32'h3);
        wr(5'h08, 32'h0000_00FF);
        rd(5'h08, 32'h0000_00FF, "R2 enable write");
        wr(5'h10, 32'h0000_0100);
        rd(5'h08, 32'h0000_01FF, "R3 set-enable");
        wr(5'h14, 32'h0000_000F);
        rd(5'h08, 32'h0000_01F0, "R3 clear-enable");

        drive(IDLEV | 32'h1); settle();
        rd(5'h00, 32'h1, "R4 rising edge captured");
        rd(5'h04, 32'h0, "R8 pending masked");
        rd(5'h18, 32'hFFFF_FFFF, "R10 vector none");
        chk_irq(1'b0, "R9 masked source");

        wr(5'h08, 32'hFFFF_FFFF);
        rd(5'h04, 32'h1, "R8 pending enabled");
        rd(5'h18, 32'h0, "R10 vector source 0");
        chk_irq(1'b1, "R9 armed and pending");

        drive(IDLEV); settle();
        rd(5'h00, 32'h1, "R4 edge held after idle");
        wr(5'h0C, 32'h1);
        rd(5'h00, 32'h0, "R6 ack clears");

        drive(IDLEV & ~32'h2); settle();
        rd(5'h00, 32'h2, "R4 falling edge captured");
        drive((IDLEV & ~32'h2) | 32'h10); settle();
        rd(5'h00, 32'h12, "R4 second rising source");
        rd(5'h18, 32'h1, "R10 lowest of two");
        wr(5'h0C, 32'h2);
        rd(5'h00, 32'h10, "R6 zero bits untouched");
        rd(5'h18, 32'h4, "R10 next source");
        drive(IDLEV); settle();
        rd(5'h00, 32'h10, "R4 returning edges ignored");

        wr(5'h1C, 32'h1);
        chk_irq(1'b0, "R9 arm bit1 clear");
        wr(5'h1C, 32'h2);
        chk_irq(1'b0, "R9 arm bit0 clear");
        wr(5'h1C, 32'h3);
        chk_irq(1'b1, "R9 fully armed");

        wr(5'h00, 32'h0);
        wr(5'h04, 32'h0);
        wr(5'h18, 32'h0);
        rd(5'h00, 32'h10, "R11 status write ignored");
        rd(5'h08, 32'hFFFF_FFFF, "R11 enable unchanged");
        rd(5'h0C, 32'h0, "R11 ack reads zero");
        rd(5'h10, 32'h0, "R11 set port reads zero");
        rd(5'h14, 32'h0, "R11 clear port reads zero");

        wr(5'h0C, 32'hFFFF_FFFF);
        rd(5'h00, 32'h0, "R6 ack all");
        rd(5'h18, 32'hFFFF_FFFF, "R10 none after ack all");

        drive(IDLEV | 32'h4); settle();
        rd(5'h00, 32'h4, "R5 active-high level");
        wr(5'h0C, 32'h4);
        rd(5'h00, 32'h4, "R5 ack while active");
        drive(IDLEV); settle();
        wr(5'h0C, 32'h4);
        rd(5'h00, 32'h0, "R5 ack after release");

        drive(IDLEV & ~32'h8); settle();
        rd(5'h00, 32'h8, "R5 active-low level");
        drive(IDLEV); settle();
        wr(5'h0C, 32'h8);
        rd(5'h00, 32'h0, "R5 low level cleared");

        drive(IDLEV | 32'h10);
        wr(5'h0C, 32'h10);
        rd(5'h00, 32'h10, "R7 edge wins over ack");
        drive(IDLEV);
        wr(5'h0C, 32'hFFFF_FFFF);

        for (int n = 0; n < 400; n++) begin
            @(posedge clk); #2;
            src_in = $urandom() & $urandom();
            src_in = src_in ^ IDLEV;
            reg_wr = ($urandom() % 3) == 0;
            reg_addr = 5'(($urandom() % 8) * 4);
            reg_wdata = ($urandom() % 4 == 0) ? 32'hFFFF_FFFF : $urandom();
        end
        @(posedge clk); #2;
        reg_wr = 1'b0;
        repeat (2) @(posedge clk);

        @(negedge clk);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule